// File: doc/BRIEF.md
# Saturating Rounding Variable Shifter

This unit shifts one vector element by a signed, per-element shift count. A negative count shifts right by its magnitude and a zero or positive count shifts left. Right shifts can round to nearest, with ties going up. Left shifts can clamp to the range of the element when bits would be lost. The element can be 8, 16, 32 or 64 bits wide. Three interpretations are supported: signed in and signed out, unsigned in and unsigned out, and signed in with an unsigned result.

The unit holds one lane and registers its result once. A vector datapath places one copy per lane and packs the lanes itself. Each operation also reports whether it clamped. A sticky flag collects those reports until a clear input resets it, so that a whole instruction sequence can be checked for saturation afterwards.

Top module: `vsh_unit`

## Requirements
- R1: The shift count is an 8-bit two's complement value. When its top bit is set, the element is shifted right by the count's magnitude (1 to 128). Otherwise it is shifted left by the count (0 to 127).
- R2: `ewidth_i` selects the element width W: 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64. Results appear on the rising edge after the inputs are presented. Result bits at W and above are always 0. Synchronous active-high reset clears the result, the per-operation flag and the sticky flag.
- R3: `mode_i` selects the interpretation: 0 signed, 1 unsigned, 2 signed operand with unsigned result, 3 same as 1. Only the low W bits of the operand are used. Mode 0 sign-extends them and every other mode zero-extends them.
- R4: With rounding off, a right shift by n < W gives the floor of operand / 2^n. In mode 0 this is an arithmetic shift.
- R5: With rounding on, a right shift by n gives floor((operand + 2^(n-1)) / 2^n). This applies to n < W in mode 0 and to n ≤ W in the unsigned modes.
- R6: In mode 0, a right shift by n ≥ W gives 0 with rounding on. With rounding off it gives the sign fill: all ones in W bits for a negative operand and 0 otherwise. In the unsigned modes, the result is 0 when n ≥ W+1 with rounding on, or when n ≥ W with rounding off.
- R7: A left shift by n < W returns the low W bits of operand·2^n. This holds when saturation is off, or when the product fits: in mode 0 it must lie in [-2^(W-1), 2^(W-1)-1], and in the unsigned modes it must be below 2^W.
- R8: A left shift by n < W with saturation on and a product that does not fit is clamped. In mode 0 the result is 2^(W-1)-1 for a non-negative operand and 2^(W-1) (the most negative value) for a negative one. In the unsigned modes it is all ones in W bits.
- R9: A left shift by n ≥ W gives 0 when saturation is off or the operand is 0. Otherwise it clamps to the value given in R8.
- R10: In mode 2 with saturation on, an operand whose bit W-1 is set gives 0 and is flagged as saturated, whatever the direction or count.
- R11: `sat_hit_o` is high exactly for an operation that clamped under R8, R9 or R10. It is therefore never high after an operation with saturation off, or after a right shift in modes 0, 1 and 3.
- R12: `sat_sticky_o` is set by every clamping operation and holds until `sat_clr_i` is sampled high. A clamp in the same cycle as a clear leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ewidth_i | input | 2 | Element width select |
| mode_i | input | 2 | Signed, unsigned or signed-to-unsigned interpretation |
| round_en_i | input | 1 | Round right shifts |
| sat_en_i | input | 1 | Clamp left shifts and negative mode-2 operands |
| operand_i | input | 64 | Element value in the low W bits |
| shamt_i | input | 8 | Signed shift count |
| sat_clr_i | input | 1 | Clear the sticky saturation flag |
| result_o | output | 64 | Shifted element, zero above W bits |
| sat_hit_o | output | 1 | The previous operation clamped |
| sat_sticky_o | output | 1 | Accumulated saturation flag |

## Verification
Every result and both flags fall due one rising edge after their inputs are presented. The bench applies each operation at a falling edge and reads the outputs 1 ns after the next rising edge. At the falling edge where the following operation is applied, it first confirms that the result still holds the previous value, so an output that arrives early is caught. The sticky flag is predicted one edge ahead from the previous expected value, the expected clamp and the clear input of the same cycle. The sweep covers every width and mode, with counts at 0, ±1, ±(W-1), ±W, ±(W+1) and the extremes, and with operands at zero, the signed limits and random values.

// File: rtl/vsh_pkg.sv
package vsh_pkg;

    localparam int unsigned DATA_W = 64;
    localparam int unsigned CNT_W  = 8;
    localparam int unsigned EXT_W  = DATA_W + 1;
    localparam int unsigned WIDE_W = 2 * DATA_W + 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } elem_w_e;

    typedef enum logic [1:0] {
        MD_SS  = 2'd0,
        MD_UU  = 2'd1,
        MD_SU  = 2'd2,
        MD_UU2 = 2'd3
    } mode_e;

    // Decoded operand and count, shared by both shift paths
    typedef struct packed {
        logic [EXT_W-1:0]  val;
        logic              is_signed;
        logic              neg;
        logic              is_zero;
        logic              right;
        cnt_t              mag;
        cnt_t              ebits;
        logic [DATA_W-1:0] mask;
    } prep_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              sat;
    } path_out_t;

    function automatic cnt_t elem_bits(elem_w_e w);
        return cnt_t'(8) << w;
    endfunction

    function automatic logic [DATA_W-1:0] elem_mask(elem_w_e w);
        return {DATA_W{1'b1}} >> (cnt_t'(DATA_W) - elem_bits(w));
    endfunction

endpackage

// File: rtl/vsh_prep.sv
module vsh_prep
    import vsh_pkg::*;
(
    input  elem_w_e           ewidth,
    input  mode_e             mode,
    input  logic [DATA_W-1:0] operand,
    input  cnt_t              shamt,
    output prep_t             p
);

    logic [DATA_W-1:0] low;
    logic              msb;
    logic              sext;

    always_comb begin
        p         = '0;
        p.ebits   = elem_bits(ewidth);
        p.mask    = elem_mask(ewidth);
        low       = operand & p.mask;
        msb       = |(low & ~(p.mask >> 1));
        p.is_signed = (mode == MD_SS);
        p.neg     = msb;
        sext      = p.is_signed & msb;
        p.val     = {sext, low | (sext ? ~p.mask : '0)};
        p.is_zero = (low == '0);
        p.right   = shamt[CNT_W-1];
        p.mag     = shamt[CNT_W-1] ? (~shamt + cnt_t'(1)) : shamt;
    end

endmodule

// File: rtl/vsh_rshift.sv
module vsh_rshift
    import vsh_pkg::*;
(
    input  logic [EXT_W-1:0]  val,
    input  logic              is_signed,
    input  logic              neg,
    input  cnt_t              mag,
    input  cnt_t              ebits,
    input  logic [DATA_W-1:0] mask,
    input  logic              round_en,
    output path_out_t         o
);

    cnt_t             limit;
    cnt_t             amt;
    logic [EXT_W-1:0] part;
    logic [EXT_W-1:0] half;
    logic             fill;

    always_comb begin
        // unsigned rounding keeps one more count alive (the top bit may round up)
        limit = ebits + ((round_en && !is_signed) ? cnt_t'(1) : cnt_t'(0));
        amt   = round_en ? (mag - cnt_t'(1)) : mag;
        part  = $unsigned($signed(val) >>> amt);
        half  = $unsigned($signed(part) >>> 1);
        fill  = is_signed && !round_en && neg;
        o.sat = 1'b0;
        if (mag >= limit) begin
            o.res = fill ? mask : '0;
        end else begin
            o.res = DATA_W'(round_en ? (half + EXT_W'(part[0])) : part) & mask;
        end
    end

endmodule

// File: rtl/vsh_lshift.sv
module vsh_lshift
    import vsh_pkg::*;
(
    input  logic [EXT_W-1:0]  val,
    input  logic              is_signed,
    input  logic              neg,
    input  logic              is_zero,
    input  cnt_t              mag,
    input  cnt_t              ebits,
    input  logic [DATA_W-1:0] mask,
    input  logic              sat_en,
    output path_out_t         o
);

    logic [WIDE_W-1:0] wide;
    logic [WIDE_W-1:0] upper;
    logic              lost;
    logic [DATA_W-1:0] clamp;

    always_comb begin
        wide = {{(WIDE_W-EXT_W){val[EXT_W-1]}}, val} << mag;
        if (is_signed) begin
            // everything from bit W-1 upward must be a pure sign run
            upper = $unsigned($signed(wide) >>> (ebits - cnt_t'(1)));
            lost  = !((upper == '0) || (upper == '1));
        end else begin
            upper = wide >> ebits;
            lost  = (upper != '0);
        end
        clamp = is_signed ? (neg ? (mask & ~(mask >> 1)) : (mask >> 1)) : mask;

        o.res = '0;
        o.sat = 1'b0;
        if (mag < ebits) begin
            if (sat_en && lost) begin
                o.res = clamp;
                o.sat = 1'b1;
            end else begin
                o.res = wide[DATA_W-1:0] & mask;
            end
        end else if (sat_en && !is_zero) begin
            o.res = clamp;
            o.sat = 1'b1;
        end
    end

endmodule

// File: rtl/vsh_unit.sv
module vsh_unit
    import vsh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        ewidth_i,
    input  logic [1:0]        mode_i,
    input  logic              round_en_i,
    input  logic              sat_en_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [CNT_W-1:0]  shamt_i,
    input  logic              sat_clr_i,
    output logic [DATA_W-1:0] result_o,
    output logic              sat_hit_o,
    output logic              sat_sticky_o
);

    prep_t     prep;
    path_out_t rs_out;
    path_out_t ls_out;
    path_out_t nxt;
    logic      su_block;

    vsh_prep u_prep (
        .ewidth  (elem_w_e'(ewidth_i)),
        .mode    (mode_e'(mode_i)),
        .operand (operand_i),
        .shamt   (shamt_i),
        .p       (prep)
    );

    vsh_rshift u_rshift (
        .val       (prep.val),
        .is_signed (prep.is_signed),
        .neg       (prep.neg),
        .mag       (prep.mag),
        .ebits     (prep.ebits),
        .mask      (prep.mask),
        .round_en  (round_en_i),
        .o         (rs_out)
    );

    vsh_lshift u_lshift (
        .val       (prep.val),
        .is_signed (prep.is_signed),
        .neg       (prep.neg),
        .is_zero   (prep.is_zero),
        .mag       (prep.mag),
        .ebits     (prep.ebits),
        .mask      (prep.mask),
        .sat_en    (sat_en_i),
        .o         (ls_out)
    );

    // negative input with unsigned result is refused before any shifting
    assign su_block = (mode_e'(mode_i) == MD_SU) && sat_en_i && prep.neg;

    always_comb begin
        if (su_block) begin
            nxt.res = '0;
            nxt.sat = 1'b1;
        end else if (prep.right) begin
            nxt = rs_out;
        end else begin
            nxt = ls_out;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o     <= '0;
            sat_hit_o    <= 1'b0;
            sat_sticky_o <= 1'b0;
        end else begin
            result_o     <= nxt.res;
            sat_hit_o    <= nxt.sat;
            sat_sticky_o <= (sat_sticky_o && !sat_clr_i) || nxt.sat;
        end
    end

    // R2: nothing leaks above the selected element width
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((result_o & ~elem_mask(elem_w_e'($past(ewidth_i)))) == '0))
        else $error("a_r2_upper_zero");

    // R9: a zero operand never produces a value or a clamp
    a_r9_zero_in: assert property (@(posedge clk) disable iff (rst)
        (operand_i == '0) |=> (result_o == '0 && !sat_hit_o))
        else $error("a_r9_zero_in");

    // R11: no clamp without saturation enabled
    a_r11_no_sat_off: assert property (@(posedge clk) disable iff (rst)
        !sat_en_i |=> !sat_hit_o)
        else $error("a_r11_no_sat_off");

    // R11: right shifts never clamp outside mode 2
    a_r11_right_no_sat: assert property (@(posedge clk) disable iff (rst)
        (shamt_i[CNT_W-1] && mode_i != 2'd2) |=> !sat_hit_o)
        else $error("a_r11_right_no_sat");

    // R12: sticky flag holds until cleared
    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        (sat_sticky_o && !sat_clr_i) |=> sat_sticky_o)
        else $error("a_r12_hold");

    // R12: every clamp is reflected in the sticky flag
    a_r12_set: assert property (@(posedge clk) disable iff (rst)
        sat_hit_o |-> sat_sticky_o)
        else $error("a_r12_set");

endmodule

// File: tb/vsh_unit_tb_top.sv
`timescale 1ns/1ps
module vsh_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  ewidth_i = '0;
    logic [1:0]  mode_i = '0;
    logic        round_en_i = 1'b0;
    logic        sat_en_i = 1'b0;
    logic [63:0] operand_i = '0;
    logic [7:0]  shamt_i = '0;
    logic        sat_clr_i = 1'b0;
    logic [63:0] result_o;
    logic        sat_hit_o;
    logic        sat_sticky_o;

    int checks = 0;
    int fails  = 0;
    logic [63:0] last_res = '0;
    bit          exp_sticky = 1'b0;

    always #2.5 clk = ~clk;

    vsh_unit dut_i (
        .clk          (clk),
        .rst          (rst),
        .ewidth_i     (ewidth_i),
        .mode_i       (mode_i),
        .round_en_i   (round_en_i),
        .sat_en_i     (sat_en_i),
        .operand_i    (operand_i),
        .shamt_i      (shamt_i),
        .sat_clr_i    (sat_clr_i),
        .result_o     (result_o),
        .sat_hit_o    (sat_hit_o),
        .sat_sticky_o (sat_sticky_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (w=%0d md=%0d rnd=%0b sat=%0b op=%h sh=%h)",
                     tag, act, exp, ewidth_i, mode_i, round_en_i, sat_en_i, operand_i, shamt_i);
        end
    endtask

    function automatic logic [63:0] wmask(int w);
        return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    endfunction

    // Arithmetic reference built from the requirements
    task automatic ref_model(input int wsel, input int md, input bit rnd, input bit sat,
                             input logic [63:0] op, input logic [7:0] sh,
                             output logic [63:0] er, output bit es, output string tag);
        int W = 8 << wsel;
        logic [63:0] m = wmask(W);
        logic [63:0] low = op & m;
        bit neg = low[W-1];
        bit sgn = (md == 0);
        int cnt = int'($signed(sh));
        logic signed [131:0] one = 132'sd1;
        logic signed [131:0] x;
        logic signed [131:0] p;
        logic signed [131:0] lim;
        logic [63:0] clampv;
        bit fits;
        x = $signed({68'd0, low});
        if (sgn && neg) x = x - (one <<< W);
        lim = one <<< (W - 1);
        clampv = sgn ? (neg ? (64'd1 << (W - 1)) : ((64'd1 << (W - 1)) - 64'd1)) : m;
        es = 1'b0;
        er = '0;
        if (md == 2 && sat && neg) begin
            tag = "R10";
            es = 1'b1;
        end else if (cnt < 0) begin
            int n = -cnt;
            int thr = sgn ? W : (W + (rnd ? 1 : 0));
            if (n >= thr) begin
                tag = "R6";
                er = (sgn && !rnd && neg) ? m : 64'd0;
            end else if (rnd) begin
                tag = "R5";
                p = (x + (one <<< (n - 1))) >>> n;
                er = p[63:0] & m;
            end else begin
                tag = "R4";
                p = x >>> n;
                er = p[63:0] & m;
            end
        end else if (cnt < W) begin
            p = x <<< cnt;
            fits = sgn ? (p >= -lim && p <= lim - one) : (p < (one <<< W));
            if (sat && !fits) begin
                tag = "R8";
                er = clampv;
                es = 1'b1;
            end else begin
                tag = "R7";
                er = p[63:0] & m;
            end
        end else begin
            tag = "R9";
            if (sat && low != 64'd0) begin
                er = clampv;
                es = 1'b1;
            end
        end
    endtask

    task automatic run_op(input int wsel, input int md, input bit rnd, input bit sat,
                          input logic [63:0] op, input logic [7:0] sh, input bit clr);
        logic [63:0] er;
        bit es;
        string tag;
        @(negedge clk);
        ewidth_i   = 2'(wsel);
        mode_i     = 2'(md);
        round_en_i = rnd;
        sat_en_i   = sat;
        operand_i  = op;
        shamt_i    = sh;
        sat_clr_i  = clr;
        ref_model(wsel, md, rnd, sat, op, sh, er, es, tag);
        #1;
        check("R2 early", result_o, last_res);
        @(posedge clk);
        #1;
        check(tag, result_o, er);
        check("R2 upper", result_o & ~wmask(8 << wsel), 64'd0);
        check("R11", {63'd0, sat_hit_o}, {63'd0, es});
        exp_sticky = (exp_sticky && !clr) || es;
        check("R12", {63'd0, sat_sticky_o}, {63'd0, exp_sticky});
        last_res = er;
    endtask

    function automatic logic [7:0] pick_sh(int ci, int W);
        int v;
        case (ci)
            0: v = 0;          1: v = 1;          2: v = -1;
            3: v = W - 1;      4: v = -(W - 1);   5: v = W;
            6: v = -W;         7: v = W + 1;      8: v = -(W + 1);
            9: v = 127;        10: v = -128;      11: v = 2;
            12: v = -2;        13: v = W - 2;     14: v = -(W - 2);
            default: v = int'($urandom_range(140)) - 70;
        endcase
        return 8'(v);
    endfunction

    function automatic logic [63:0] pick_op(int oi, int W);
        case (oi)
            0: return 64'd0;
            1: return 64'd1;
            2: return 64'hFFFF_FFFF_FFFF_FFFF;
            3: return wmask(W) >> 1;
            4: return 64'd1 << (W - 1);
            5: return (64'd1 << (W - 1)) | 64'd1;
            6: return 64'hA5A5_5A5A_C3C3_3C3C;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run hung (all requirements), actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        operand_i = 64'hFFFF_0000_FFFF_0000;
        shamt_i   = 8'h03;
        sat_en_i  = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        // R2 reset state
        check("R2 reset result", result_o, 64'd0);
        check("R12 reset sticky", {63'd0, sat_sticky_o}, 64'd0);
        check("R11 reset hit", {63'd0, sat_hit_o}, 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // R1 direction from the count sign
        run_op(1, 0, 0, 0, 64'h0010, 8'h01, 0);
        check("R1 left", result_o, 64'h0020);
        run_op(1, 0, 0, 0, 64'h0010, 8'hFF, 0);
        check("R1 right", result_o, 64'h0008);

        // R3 extension by mode, garbage above the element ignored
        run_op(0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FF80, 8'hFF, 0);
        check("R3 signed", result_o, 64'h00C0);
        run_op(0, 1, 0, 0, 64'h1234_0000_0000_0080, 8'hFF, 0);
        check("R3 unsigned", result_o, 64'h0040);

        // R12 sticky: set, hold, clear, set-wins-over-clear
        run_op(0, 0, 0, 1, 64'h7F, 8'h01, 0);
        run_op(0, 0, 0, 0, 64'h01, 8'h01, 0);
        check("R12 hold", {63'd0, sat_sticky_o}, 64'd1);
        run_op(0, 0, 0, 0, 64'h01, 8'h01, 1);
        check("R12 clear", {63'd0, sat_sticky_o}, 64'd0);
        run_op(0, 1, 0, 1, 64'hFF, 8'h04, 1);
        check("R12 set wins", {63'd0, sat_sticky_o}, 64'd1);

        for (int w = 0; w < 4; w++) begin
            for (int md = 0; md < 4; md++) begin
                for (int r = 0; r < 2; r++) begin
                    for (int s = 0; s < 2; s++) begin
                        for (int ci = 0; ci < 18; ci++) begin
                            for (int oi = 0; oi < 10; oi++) begin
                                run_op(w, md, r[0], s[0], pick_op(oi, 8 << w),
                                       pick_sh(ci, 8 << w), ($urandom_range(7) == 0));
                            end
                        end
                    end
                end
            end
        end

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule